// File: doc/BRIEF.md
# Shared-Line Synchronization Period Timer

This block measures a programmable interval in whole seconds. At the end of each interval it pulls a shared, active-low, open-drain sync line low for a short time. Several devices share that line. Each device also watches the line, and any falling edge on it restarts the local seconds count and sends a one-cycle resync strobe to the local dividers. The device whose interval ends first therefore sets the timing for the whole group.

The interval is the 4-bit period field plus one, in seconds. It is counted with a once-per-second tick enable. Synchronization runs only when the enable strap is high and the period field is non-zero. Otherwise the block leaves the line alone and ignores any activity on it. The pull-up resistor and the pad are outside the block. The block only gives a pull-down enable and reads back the sensed level of the line.

Top module: `sync_period_gen`

## Requirements
- R1: After reset, `line_pull` and `resync` are both low.
- R2: With the enable strap high and a period field N (1 to 15), the first drive of the line starts on the (N+1)th `sec_tick` after reset or after the last resync, and not on an earlier tick.
- R3: Each drive holds `line_pull` high for exactly `PULSE_CYC` clock cycles (default 4) and then releases it.
- R4: The sensed line passes through two flops. `resync` goes high right after the second rising clock edge that samples `line_in` low. It stays high for one cycle, and a line held low gives no further strobe.
- R5: A low pulse driven on the line by another device restarts the local count. The next local drive comes on the (N+1)th tick after that event.
- R6: The block's own drive also restarts its count through the same path, so drives repeat every N+1 ticks.
- R7: While the enable strap is low, `line_pull` stays low on any number of ticks, and falling edges on `line_in` produce no `resync`.
- R8: A period field of 0 disables the block in the same way as a low strap: no drive and no `resync`.
- R9: If the period field is lowered to a value at or below the seconds already counted, the drive starts on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle enable, once per second |
| sync_en | input | 1 | Enable strap for synchronization |
| period_sel | input | 4 | Period field, interval = value + 1 seconds, 0 = off |
| line_in | input | 1 | Sensed level of the shared sync line (low = asserted) |
| line_pull | output | 1 | Pull-down enable for the open-drain sync line |
| resync | output | 1 | One-cycle restart strobe to local dividers |

## Verification
The bench models the wired-AND line from the block's own pull-down and an external pull-down. This lets it exercise the block in four ways: alone, where drives must repeat every N+1 ticks; with an outside device pulsing the line partway through a count, which tells a restart apart from a free-running count; with the line held low for a long time, which shows that the block reacts to the edge and not to the level; and with the strap low or the field at zero, where neither ticks nor line activity may have any effect. Lowering the period field in the middle of a count separates a magnitude compare from an equality compare.

// File: rtl/sync_period_pkg.sv
package sync_period_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] period_t;
endpackage

// File: rtl/line_sampler.sv
module line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_fall
);
  logic meta_q, meta_d;
  logic stab_q, stab_d;
  logic prev_q, prev_d;

  always_comb begin
    meta_d = line_in;
    stab_d = meta_q;
    prev_d = stab_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      prev_q <= prev_d;
    end
  end

  assign line_fall = prev_q & ~stab_q;

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> !line_fall); // R4
endmodule

// File: rtl/sec_counter.sv
module sec_counter
  import sync_period_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    active,
  input  logic    sec_tick,
  input  period_t period_sel,
  input  logic    restart,
  output logic    period_end
);
  period_t cnt_q, cnt_d;

  assign period_end = active & sec_tick & (cnt_q >= period_sel);

  always_comb begin
    cnt_d = cnt_q;
    if (!active || restart || period_end) begin
      cnt_d = '0;
    end else if (sec_tick) begin
      cnt_d = cnt_q + period_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0); // R5

  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (sec_tick && period_sel != '0)); // R2
endmodule

// File: rtl/pull_driver.sv
module pull_driver #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic start,
  output logic pull
);
  localparam int unsigned W = $clog2(PULSE_CYC + 1);

  logic [W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (!active) begin
      left_d = '0;
    end else if (start && left_q == '0) begin
      left_d = W'(PULSE_CYC);
    end else if (left_q != '0) begin
      left_d = left_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end

  assign pull = (left_q != '0);

  AST_PULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && active && left_q != W'(1)) |=> pull); // R3

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pull); // R7
endmodule

// File: rtl/sync_period_gen.sv
module sync_period_gen
  import sync_period_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       sync_en,
  input  logic [3:0] period_sel,
  input  logic       line_in,
  output logic       line_pull,
  output logic       resync
);
  logic active;
  logic line_fall;
  logic period_end;

  assign active = sync_en & (|period_sel);

  line_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_fall (line_fall)
  );

  assign resync = active & line_fall;

  sec_counter u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .sec_tick   (sec_tick),
    .period_sel (period_t'(period_sel)),
    .restart    (resync),
    .period_end (period_end)
  );

  pull_driver #(.PULSE_CYC(PULSE_CYC)) u_driver (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .start  (period_end),
    .pull   (line_pull)
  );

  AST_OFF_NO_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en || period_sel == 4'd0) |-> !resync); // R8
endmodule

// File: tb/test_sync_period_gen.sv
module test_sync_period_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic sync_en = 1'b0;
  logic [3:0] period_sel = 4'd0;
  logic ext_low = 1'b0;
  logic line_in;
  logic line_pull;
  logic resync;

  int checks = 0;
  int fails = 0;
  int pulls = 0;
  int resyncs = 0;
  int run_len = 0;
  int last_len = 0;
  logic pull_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign line_in = ~(line_pull | ext_low);

  sync_period_gen i_sync_period_gen (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sync_en(sync_en),
    .period_sel(period_sel), .line_in(line_in),
    .line_pull(line_pull), .resync(resync)
  );

  always @(negedge clk) begin
    if (line_pull && !pull_prev) pulls++;
    if (line_pull) run_len++;
    else if (pull_prev) begin last_len = run_len; run_len = 0; end
    if (resync) resyncs++;
    pull_prev = line_pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic ext_pulse(input int len);
    @(negedge clk) ext_low = 1'b1;
    repeat (len) @(negedge clk);
    ext_low = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    sync_en = 1'b1; period_sel = 4'd3;
    do_reset();
    chk("R1 pull", int'(line_pull), 0);
    chk("R1 resync", int'(resync), 0);
  endtask

  task automatic t_period(input int n);
    int p0;
    sync_en = 1'b1; period_sel = 4'(n);
    do_reset();
    p0 = pulls;
    for (int k = 0; k < n; k++) do_tick();
    chk("R2 no early drive", pulls - p0, 0);
    do_tick();
    chk("R2 drive on tick N+1", pulls - p0, 1);
    chk("R3 pulse length", last_len, 4);
    for (int k = 0; k < n; k++) do_tick();
    chk("R6 no early repeat", pulls - p0, 1);
    do_tick();
    chk("R6 repeat after N+1", pulls - p0, 2);
  endtask

  task automatic t_strobe();
    int r0;
    sync_en = 1'b1; period_sel = 4'd5;
    do_reset();
    r0 = resyncs;
    @(negedge clk) ext_low = 1'b1;
    @(negedge clk) chk("R4 not after first edge", int'(resync), 0);
    @(negedge clk) chk("R4 high after second edge", int'(resync), 1);
    @(negedge clk) chk("R4 one cycle", int'(resync), 0);
    repeat (12) @(negedge clk);
    chk("R4 held low single strobe", resyncs - r0, 1);
    ext_low = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_external();
    int p0;
    sync_en = 1'b1; period_sel = 4'd3;
    do_reset();
    p0 = pulls;
    do_tick(); do_tick(); do_tick();
    ext_pulse(3);
    for (int k = 0; k < 3; k++) do_tick();
    chk("R5 restart delays drive", pulls - p0, 0);
    do_tick();
    chk("R5 drive N+1 after resync", pulls - p0, 1);
  endtask

  task automatic t_disabled(input logic en, input logic [3:0] sel, input string req);
    int p0, r0;
    sync_en = en; period_sel = sel;
    do_reset();
    p0 = pulls; r0 = resyncs;
    for (int k = 0; k < 20; k++) do_tick();
    chk(req, pulls - p0, 0);
    ext_pulse(4);
    chk(req, resyncs - r0, 0);
  endtask

  task automatic t_lower();
    int p0;
    sync_en = 1'b1; period_sel = 4'd5;
    do_reset();
    p0 = pulls;
    do_tick(); do_tick(); do_tick();
    chk("R9 no drive yet", pulls - p0, 0);
    period_sel = 4'd2;
    do_tick();
    chk("R9 drive on next tick", pulls - p0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_period(1);
    t_period(3);
    t_period(15);
    t_strobe();
    t_external();
    t_disabled(1'b0, 4'd2, "R7 strap low");
    t_disabled(1'b1, 4'd0, "R8 field zero");
    t_lower();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule